// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Rewind

This block is a first-in first-out store with a parameterised power-of-two depth and a 9-bit word. It is controlled by two active-low strobes, one for writing and one for reading. A single system clock samples both strobes, and the block finds their edges itself. A falling edge opens a cycle and a rising edge closes it. A write cycle stores the word present on the data input when its strobe rises. A read cycle presents the oldest word for as long as its strobe stays low. An output-enable indication stands in for a tri-state data bus.

The block drives three active-low status outputs: empty, full and half-full. Full and half-full react to the falling edge of a write and recover on the rising edge of a read. Empty reacts to the falling edge of a read and recovers on the rising edge of a write. An active-low retransmit input rewinds the read side to the first location so that the stored words can be replayed, and leaves the write side where it is. An active-low reset is needed before the first write is accepted.

Top module: `strobe_fifo`

## Requirements
- R1: One clock after `rst_n` is sampled low, both pointers are at location zero. The outputs read `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0.
- R2: From power-up until the first reset, write strobes are ignored and `empty_n` stays 0.
- R3: A write opens on the clock where `wr_n` is sampled low after being high, if `full_n` is 1. It stores `din` as sampled on the clock where `wr_n` is seen high again. `empty_n` becomes 1 one clock after that.
- R4: `full_n` drops one clock after the falling strobe of the write that brings occupancy to DEPTH. It stays low until one clock after the rising strobe of the next accepted read. Occupancy never exceeds DEPTH.
- R5: Write strobes while `full_n`=0 and read strobes while `empty_n`=0 are ignored. They move no pointer and change no flag or data.
- R6: A read opens on a sampled falling `rd_n` when `empty_n` is 1. One clock later `dout_oe`=1 and `dout` holds the oldest unread word. Words leave in write order.
- R7: `empty_n` drops one clock after the falling strobe of the read that takes the last stored word. `empty_n` and `full_n` are never low together.
- R8: `dout_oe` returns to 0 one clock after `rd_n` is sampled high. It never rises for a refused read.
- R9: `half_n` drops one clock after the falling strobe of a write that raises occupancy above DEPTH/2. It rises one clock after the rising strobe of a read that leaves occupancy at or below DEPTH/2. Whenever `full_n` is 0, `half_n` is 0.
- R10: While `rt_n` is sampled low, the read pointer returns to location zero. Occupancy becomes the number of words written since reset, which must be at most DEPTH. The write pointer is unchanged. The flags follow from the new occupancy one clock later.
- R11: Strobe edges sampled while `rst_n` or `rt_n` is low start no cycle and complete no cycle.
- R12: Ordering holds across pointer wrap-around. A read and a write that complete on the same clock both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Retransmit (read rewind), active low |
| din | input | WIDTH | Write data, captured when the write strobe rises |
| dout | output | WIDTH | Read data, meaningful while dout_oe is 1 |
| dout_oe | output | 1 | Read data drive enable |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | Half-full flag, active low |

## Verification
The bench fills the store to the last slot and then strobes once more. A design that lets this extra write through would overwrite the oldest word, and that word would then come out wrong. The bench also strobes reads on an empty store. A design that lets those through would raise the output enable or step the read pointer, and later data would come out out of order. For every fill level from zero to DEPTH, the bench drains part of the contents, rewinds, and replays everything. A rewind that restored the wrong occupancy would show wrong flags or too few words. Two further cases run the pointers past the end of the array and complete a read and a write on the same clock; a design that got either wrong would lose or duplicate a word. Half-full is checked separately on both its setting edge and its clearing edge, so a flag updated on the wrong edge fails.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Indices of the two strobe lanes in the edge-detector array.
  localparam int unsigned STB_WR = 0;
  localparam int unsigned STB_RD = 1;
  localparam int unsigned N_STB  = 2;

  // Active-low status bundle produced by the flag logic.
  typedef struct packed {
    logic empty_n;
    logic half_n;
    logic full_n;
  } fifo_flags_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);
  logic prev_n = 1'b1;

  always_ff @(posedge clk) begin
    prev_n <= strobe_n;
  end

  assign fall = prev_n & ~strobe_n;
  assign rise = ~prev_n & strobe_n;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] occ_hi,
  input  logic [CW-1:0] occ_lo,
  output fifo_flags_t   flags
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

  always_comb begin
    flags.full_n  = (occ_hi != FULL_LVL);
    flags.half_n  = (occ_hi <= HALF_LVL);
    flags.empty_n = (occ_lo != '0);
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  // Strobe edge detection, one lane per strobe.
  logic [N_STB-1:0] stb_n;
  logic [N_STB-1:0] stb_fall;
  logic [N_STB-1:0] stb_rise;

  assign stb_n[STB_WR] = wr_n;
  assign stb_n[STB_RD] = rd_n;

  generate
    for (genvar g = 0; g < N_STB; g++) begin : g_edge
      strobe_edge u_edge (
        .clk      (clk),
        .strobe_n (stb_n[g]),
        .fall     (stb_fall[g]),
        .rise     (stb_rise[g])
      );
    end
  endgenerate

  // Control state. Power-up values keep writes locked until a reset.
  logic          armed   = 1'b0;
  logic          lap     = 1'b0;
  logic          wr_busy = 1'b0;
  logic          rd_busy = 1'b0;
  logic [AW-1:0] wr_ptr  = '0;
  logic [AW-1:0] rd_ptr  = '0;
  logic [CW-1:0] cnt     = '0;

  fifo_flags_t   flags;
  logic          quiet;
  logic          wr_start, wr_done, rd_start, rd_done;
  logic [CW-1:0] occ_hi, occ_lo, since_reset;

  assign quiet    = rst_n & rt_n;
  assign wr_start = quiet & armed & stb_fall[STB_WR] & flags.full_n;
  assign wr_done  = quiet & wr_busy & stb_rise[STB_WR];
  assign rd_start = quiet & stb_fall[STB_RD] & flags.empty_n;
  assign rd_done  = quiet & rd_busy & stb_rise[STB_RD];

  // Occupancy seen by the flags: an open write counts toward full and
  // half-full, an open read already counts against empty.
  assign occ_hi = cnt + CW'(wr_busy);
  assign occ_lo = cnt - CW'(rd_busy);

  // Words written since reset; exact for up to DEPTH writes.
  assign since_reset = (lap && wr_ptr == '0) ? CW'(DEPTH) : CW'(wr_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b1;
      lap     <= 1'b0;
      wr_busy <= 1'b0;
      rd_busy <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
    end else if (!rt_n) begin
      rd_ptr  <= '0;
      cnt     <= since_reset;
      wr_busy <= 1'b0;
      rd_busy <= 1'b0;
    end else begin
      if (wr_start)     wr_busy <= 1'b1;
      else if (wr_done) wr_busy <= 1'b0;
      if (rd_start)     rd_busy <= 1'b1;
      else if (rd_done) rd_busy <= 1'b0;
      if (wr_done) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (wr_ptr == LAST_ADDR) lap <= 1'b1;
      end
      if (rd_done) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(wr_done) - CW'(rd_done);
    end
  end

  fifo_ram #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) u_ram (
    .clk   (clk),
    .we    (wr_done),
    .waddr (wr_ptr),
    .wdata (din),
    .re    (rd_start),
    .raddr (rd_ptr),
    .rdata (dout)
  );

  fifo_flags #(
    .DEPTH (DEPTH)
  ) u_flags (
    .occ_hi (occ_hi),
    .occ_lo (occ_lo),
    .flags  (flags)
  );

  assign dout_oe = rd_busy;
  assign empty_n = flags.empty_n;
  assign full_n  = flags.full_n;
  assign half_n  = flags.half_n;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic          dout_oe,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          wr_busy,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] cnt
);
  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (!empty_n && full_n && half_n && !dout_oe)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R4
  AST_FULL_FREEZES_WR: assert property (@(posedge clk) disable iff (!rst_n) (!full_n && !wr_busy) |=> $stable(wr_ptr)); // R5
  AST_EMPTY_FREEZES_RD: assert property (@(posedge clk) disable iff (!rst_n) (!empty_n && !dout_oe && rt_n) |=> $stable(rd_ptr)); // R5
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !(!full_n && !empty_n)); // R7
  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (dout_oe && rd_n) |=> !dout_oe); // R8
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n) !full_n |-> !half_n); // R9
  AST_RT_REWIND: assert property (@(posedge clk) disable iff (!rst_n) !rt_n |=> (rd_ptr == '0 && !dout_oe)); // R10
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_n    (rd_n),
  .rt_n    (rt_n),
  .dout_oe (dout_oe),
  .empty_n (empty_n),
  .full_n  (full_n),
  .half_n  (half_n),
  .wr_busy (wr_busy),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr),
  .cnt     (cnt)
);

// File: tb/strobe_fifo_tb.sv
module strobe_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 9;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic dout_oe, empty_n, full_n, half_n;

  int n_chk = 0, n_fail = 0;
  bit armed_m = 1'b0;
  int q[$];
  int hist[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  strobe_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "empty_n after reset", empty_n, 0);
    chk("R1", "full_n after reset", full_n, 1);
    chk("R1", "half_n after reset", half_n, 1);
    chk("R1", "dout_oe after reset", dout_oe, 0);
    rst_n = 1'b1;
    q.delete();
    hist.delete();
    armed_m = 1'b1;
  endtask

  task automatic wr_word(input int d);
    int c = q.size();
    bit acc = armed_m && (c < DEPTH);
    @(negedge clk) wr_n = 1'b0;
    @(negedge clk);
    if (acc) begin
      chk("R4", "full_n at write fall", full_n, (c + 1 == DEPTH) ? 0 : 1);
      chk("R9", "half_n at write fall", half_n, (c + 1 > DEPTH / 2) ? 0 : 1);
      chk("R3", "empty_n before commit", empty_n, (c != 0) ? 1 : 0);
    end else begin
      chk("R5", "full_n on refused write", full_n, (c == DEPTH) ? 0 : 1);
    end
    din = WIDTH'(d);
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk);
    if (acc) begin
      q.push_back(d);
      hist.push_back(d);
      chk("R3", "empty_n after commit", empty_n, 1);
    end else if (!armed_m) begin
      chk("R2", "empty_n after pre-reset write", empty_n, 0);
    end else begin
      chk("R5", "full_n kept after refused write", full_n, 0);
    end
  endtask

  task automatic rd_word();
    int c = q.size();
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk);
    if (c > 0) begin
      chk("R6", "dout_oe during read", dout_oe, 1);
      chk("R6", "dout order", dout, q[0]);
      chk("R7", "empty_n at read fall", empty_n, (c - 1 != 0) ? 1 : 0);
      chk("R4", "full_n held during read", full_n, (c == DEPTH) ? 0 : 1);
    end else begin
      chk("R8", "dout_oe on refused read", dout_oe, 0);
      chk("R5", "empty_n on refused read", empty_n, 0);
    end
    @(negedge clk) rd_n = 1'b1;
    @(negedge clk);
    chk("R8", "dout_oe after strobe rise", dout_oe, 0);
    if (c > 0) begin
      void'(q.pop_front());
      c--;
      chk("R4", "full_n after read", full_n, (c == DEPTH) ? 0 : 1);
      chk("R9", "half_n after read", half_n, (c > DEPTH / 2) ? 0 : 1);
    end
  endtask

  task automatic check_flags(input string req);
    int c = q.size();
    chk(req, "empty_n", empty_n, (c != 0) ? 1 : 0);
    chk(req, "full_n", full_n, (c == DEPTH) ? 0 : 1);
    chk(req, "half_n", half_n, (c > DEPTH / 2) ? 0 : 1);
    chk(req, "dout_oe", dout_oe, 0);
  endtask

  task automatic retransmit();
    @(negedge clk) rt_n = 1'b0;
    @(negedge clk) rt_n = 1'b1;
    q = hist;
    check_flags("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: write before any reset is refused
    wr_word(9'h055);
    do_reset();

    // Full fill, one refused write, full drain, one refused read.
    for (int i = 0; i < DEPTH; i++) wr_word(i * 37 + 3);
    wr_word(9'h1ff);                       // R5 refused while full
    for (int i = 0; i < DEPTH; i++) rd_word();
    rd_word();                             // R5 refused while empty

    // R10 sweep: each fill level, partial drain, rewind, full replay.
    for (int k = 0; k <= DEPTH; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) wr_word((k * 53 + i * 11 + 1) % 512);
      if (k == DEPTH) wr_word(9'h0aa);
      for (int j = 0; j < k / 2; j++) rd_word();
      retransmit();
      while (q.size() > 0) rd_word();
      rd_word();
    end

    // R11: strobes during reset are ignored.
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    q.delete(); hist.delete(); armed_m = 1'b1;
    @(negedge clk);
    chk("R11", "empty_n after strobes in reset", empty_n, 0);
    chk("R11", "half_n after strobes in reset", half_n, 1);

    // R11: strobes during retransmit are ignored.
    for (int i = 0; i < 3; i++) wr_word(100 + i);
    rd_word();
    @(negedge clk) rt_n = 1'b0;
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk) begin rd_n = 1'b1; wr_n = 1'b0; din = 9'h133; end
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk) rt_n = 1'b1;
    q = hist;
    @(negedge clk);
    check_flags("R11");
    while (q.size() > 0) rd_word();

    // R12: wrap-around ordering.
    do_reset();
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 5; i++) wr_word(200 + r * 10 + i);
      for (int i = 0; i < 5; i++) rd_word();
    end

    // R12: read and write complete on the same clock.
    for (int i = 0; i < 3; i++) wr_word(300 + i);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk) rd_n = 1'b0;
      @(negedge clk) begin wr_n = 1'b0; din = WIDTH'(400 + r); end
      @(negedge clk);
      chk("R12", "dout during overlap", dout, q[0]);
      chk("R12", "dout_oe during overlap", dout_oe, 1);
      rd_n = 1'b1;
      wr_n = 1'b1;
      @(negedge clk);
      void'(q.pop_front());
      q.push_back(400 + r);
      check_flags("R12");
    end
    while (q.size() > 0) rd_word();
    check_flags("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule